// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is a purely combinational arithmetic/logic unit. It is built from identical one-bit cells joined by a ripple carry. It takes two operand buses and a two-bit operation code. It returns a result bus and the carry leaving the most significant cell. The four operations are bitwise AND, bitwise OR, addition and two's-complement subtraction.

Each cell holds:

- an AND gate;
- an OR gate;
- a full adder whose second input can be complemented;
- a tree of three 2:1 multiplexers that picks the cell's result.

Subtraction complements B in every cell and sets the carry into the lowest cell. By default a single opcode bit drives both the complement and the carry-in. As a result, the carry output during OR reflects an A minus B computation. A parameter selects a gated mode instead. In that mode the complement and carry-in are asserted only for subtraction, and the carry output is forced low for both logic operations.

Top module: `slice_alu`

## Requirements
- R1: With op_i = 2'b00, z_o equals a_i AND b_i bit for bit.
- R2: With op_i = 2'b01, z_o equals (a_i + b_i) mod 2^WIDTH and cout_o equals the carry out of that sum, in both modes.
- R3: With op_i = 2'b10, z_o equals a_i OR b_i bit for bit.
- R4: With op_i = 2'b11, z_o equals (a_i - b_i) mod 2^WIDTH and cout_o is 1 exactly when a_i >= b_i as unsigned numbers (no borrow).
- R5: With GATE_COUT = 0 and op_i = 2'b10, cout_o equals the carry of a_i + ~b_i + 1, which is 1 exactly when a_i >= b_i.
- R6: With GATE_COUT = 0 and op_i = 2'b00, cout_o equals the carry out of a_i + b_i.
- R7: With GATE_COUT = 1, cout_o is 0 for op_i = 2'b00 and op_i = 2'b10, and z_o is as in R1 and R3.
- R8: Carry ripples through every cell. With WIDTH = 8, 0xFF + 0x01 gives z_o = 0x00 and cout_o = 1, and 0x00 - 0x01 gives z_o = 0xFF and cout_o = 0.
- R9: With WIDTH = 8, the unit gives:
  - 0x1F AND 0x01 = 0x01
  - 0x1F + 0x01 = 0x20
  - 0x1F OR 0x01 = 0x1F
  - 0x1F - 0x01 = 0x1E with cout_o = 1
  - 0x88 + 0x11 = 0x99

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 2 | Operation code: 00 AND, 01 ADD, 10 OR, 11 SUB |
| z_o | output | WIDTH | Result |
| cout_o | output | 1 | Carry out of the top cell |

## Verification
The hardest cases to reach are full-length carry propagation and the operand pairs where a_i equals b_i or sits one away from it. At those pairs the subtraction carry, and the OR-mode carry in the default configuration, change value. The stimulus steps a_i through every value against a fixed set of b_i values. That set includes all-zeros, all-ones, the sign boundaries and both neighbours of a run of ones. Together these cover every carry chain length and both sides of the equality boundary. Two instances, one per carry mode, see identical stimulus.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_ADD = 2'b01,
    OP_OR  = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;
endpackage

// File: rtl/slice_alu_ctrl.sv
module slice_alu_ctrl #(
  parameter bit GATE_COUT = 1'b0
) (
  input  logic [1:0] op_i,
  output logic       inv_o,
  output logic       cin_o,
  output logic       keep_o
);
  generate
    if (GATE_COUT) begin : g_gated
      always_comb begin
        inv_o  = op_i[1] & op_i[0];
        cin_o  = op_i[1] & op_i[0];
        keep_o = op_i[0];
      end
    end else begin : g_plain
      always_comb begin
        inv_o  = op_i[1];
        cin_o  = op_i[1];
        keep_o = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/slice_alu_cell.sv
module slice_alu_cell (
  input  logic       a_i,
  input  logic       b_i,
  input  logic       inv_i,
  input  logic       cin_i,
  input  logic [1:0] op_i,
  output logic       z_o,
  output logic       cout_o
);
  logic and_v, or_v, b_eff, sum_v, lo_mux, hi_mux;

  always_comb begin
    and_v  = a_i & b_i;
    or_v   = a_i | b_i;
    b_eff  = inv_i ? ~b_i : b_i;
    sum_v  = a_i ^ b_eff ^ cin_i;
    cout_o = (a_i & b_eff) | (cin_i & (a_i ^ b_eff));
    lo_mux = op_i[0] ? sum_v : and_v;
    hi_mux = op_i[0] ? sum_v : or_v;
    z_o    = op_i[1] ? hi_mux : lo_mux;
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter bit          GATE_COUT = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       op_i,
  output logic [WIDTH-1:0] z_o,
  output logic             cout_o
);
  localparam int unsigned EXT = WIDTH + 1;

  logic           inv, cin0, keep;
  logic [WIDTH:0] carry;

  slice_alu_ctrl #(.GATE_COUT(GATE_COUT)) ctrl_i (
    .op_i  (op_i),
    .inv_o (inv),
    .cin_o (cin0),
    .keep_o(keep)
  );

  assign carry[0] = cin0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    slice_alu_cell cell_i (
      .a_i   (a_i[i]),
      .b_i   (b_i[i]),
      .inv_i (inv),
      .cin_i (carry[i]),
      .op_i  (op_i),
      .z_o   (z_o[i]),
      .cout_o(carry[i+1])
    );
  end

  assign cout_o = carry[WIDTH] & keep;

  logic [EXT-1:0] ref_add;
  logic [EXT-1:0] ref_sub;
  always_comb begin
    ref_add = EXT'(a_i) + EXT'(b_i);
    ref_sub = EXT'(a_i) + EXT'(~b_i) + EXT'(1);
    if (op_i == OP_AND)
      p_and_r1: assert (z_o == (a_i & b_i));
    if (op_i == OP_ADD)
      p_add_r2: assert ({cout_o, z_o} == ref_add);
    if (op_i == OP_OR)
      p_or_r3: assert (z_o == (a_i | b_i));
    if (op_i == OP_SUB)
      p_sub_r4: assert (z_o == ref_sub[WIDTH-1:0] && cout_o == (a_i >= b_i));
    if (!GATE_COUT && op_i == OP_OR)
      p_or_carry_r5: assert (cout_o == (a_i >= b_i));
    if (!GATE_COUT && op_i == OP_AND)
      p_and_carry_r6: assert (cout_o == ref_add[WIDTH]);
    if (GATE_COUT && !op_i[0])
      p_gated_zero_r7: assert (cout_o == 1'b0);
  end
endmodule

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a, b, z, zg;
  logic [1:0]   op;
  logic         c, cg;
  int n_vec = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  slice_alu #(.WIDTH(W), .GATE_COUT(1'b0)) dut_i (
    .a_i(a), .b_i(b), .op_i(op), .z_o(z), .cout_o(c));
  slice_alu #(.WIDTH(W), .GATE_COUT(1'b1)) dut_g_i (
    .a_i(a), .b_i(b), .op_i(op), .z_o(zg), .cout_o(cg));

  task automatic chk(string req, logic [W-1:0] gz, logic gc,
                     logic [W-1:0] ez, logic ec);
    n_vec++;
    if (gz !== ez || gc !== ec) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h op=%b got z=%h c=%b exp z=%h c=%b",
               req, a, b, op, gz, gc, ez, ec);
    end
  endtask

  task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb, logic [1:0] top);
    @(posedge clk);
    a = ta; b = tb; op = top;
    @(negedge clk);
  endtask

  // expected values computed arithmetically
  task automatic check_both();
    logic [W:0] s, d;
    s = {1'b0, a} + {1'b0, b};
    d = {1'b0, a} + {1'b0, ~b} + 9'd1;
    case (op)
      2'b00: begin
        chk("R1/R6", z, c, a & b, s[W]);
        chk("R1/R7", zg, cg, a & b, 1'b0);
      end
      2'b01: begin
        chk("R2", z, c, s[W-1:0], s[W]);
        chk("R2", zg, cg, s[W-1:0], s[W]);
      end
      2'b10: begin
        chk("R3/R5", z, c, a | b, a >= b);
        chk("R3/R7", zg, cg, a | b, 1'b0);
      end
      default: begin
        chk("R4", z, c, d[W-1:0], a >= b);
        chk("R4", zg, cg, d[W-1:0], a >= b);
      end
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  logic [W-1:0] bset [16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h1F, 8'h3C,
                              8'h55, 8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC3,
                              8'hF0, 8'hFE, 8'hFF};

  initial begin
    a = '0; b = '0; op = 2'b00;
    @(negedge clk);
    // reset-free combinational start: zero inputs
    chk("R1", z, c, 8'h00, 1'b0);
    // R9 reference vectors
    apply(8'h1F, 8'h01, 2'b00); chk("R9", z, c, 8'h01, 1'b0);
    apply(8'h1F, 8'h01, 2'b01); chk("R9", z, c, 8'h20, 1'b0);
    apply(8'h1F, 8'h01, 2'b10); chk("R9", z, c, 8'h1F, 1'b1);
    apply(8'h1F, 8'h01, 2'b11); chk("R9", z, c, 8'h1E, 1'b1);
    apply(8'h88, 8'h11, 2'b01); chk("R9", z, c, 8'h99, 1'b0);
    // R8 full ripple
    apply(8'hFF, 8'h01, 2'b01); chk("R8", z, c, 8'h00, 1'b1);
    apply(8'h00, 8'h01, 2'b11); chk("R8", z, c, 8'hFF, 1'b0);
    apply(8'h00, 8'h01, 2'b11); chk("R8", zg, cg, 8'hFF, 1'b0);
    // R7 gated logic ops with carrying operands
    apply(8'hFF, 8'hFF, 2'b00); chk("R7", zg, cg, 8'hFF, 1'b0);
    apply(8'hFF, 8'h00, 2'b10); chk("R7", zg, cg, 8'hFF, 1'b0);
    // sweep
    for (int o = 0; o < 4; o++)
      for (int ia = 0; ia < 256; ia++)
        for (int ib = 0; ib < 16; ib++) begin
          apply(W'(ia), bset[ib], 2'(o));
          check_both();
        end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule